// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel. Software fills in a source address, a destination address and an item count. It then sets the enable bit. The channel moves the items one at a time over a simple memory-mapped master port: one read from the source, then one write to the destination. Each side has its own item size (byte, half-word or word) and its own address-increment switch. This lets the same engine copy one buffer to another, drain a fixed peripheral data register into a buffer, or fill a fixed register from a buffer.

The channel runs in one of two pacing modes. In free-running mode it moves items back to back. In request-paced mode it moves exactly one item for each rising edge on a request line. Three sticky flags report progress: one at the midpoint of the count, one when the last item has been written, and one on a bus error. Software clears them through a write-one-to-clear register, and each flag has its own interrupt enable. In circular mode the channel restores its count and both start addresses when the count runs out, so a ring buffer can be serviced half by half using the midpoint and completion flags.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset every register reads zero and no bus request is issued. Registers are word indices: 0 control, 1 source base, 2 destination base, 3 count (reads back the remaining count), 4 flags (read-only), 5 flag-clear (write-only, reads zero). Control bits: [0] enable, [1] free-running, [2] circular, [3] source increment, [4] destination increment, [6:5] source size, [8:7] destination size, [10:9] priority (stored only), [11] completion interrupt enable, [12] midpoint interrupt enable, [13] error interrupt enable. Flag bits: [0] complete, [1] midpoint, [2] error.
- R2: Setting the enable bit while the programmed count is zero leaves the channel disabled.
- R3: In free-running mode (control bit 1 set) all items move without any request pulse.
- R4: In request-paced mode (control bit 1 clear) no item moves until a rising edge on `dreq`, and each rising edge moves exactly one item.
- R5: Size code 0 is a byte, 1 a half-word and 2 a word, and it is driven on `bus_size` for that side's accesses. The read item is zero-extended from the source size, and its low destination-size bytes are written.
- R6: After each item, an address whose increment bit is set advances by 1, 2 or 4 according to that side's size. An address whose increment bit is clear stays at its base.
- R7: When the last item has been written, the complete flag sets. In non-circular mode the enable bit clears and the remaining count reads zero.
- R8: With count N, the midpoint flag sets when the completed item count reaches N minus floor(N/2).
- R9: In circular mode the completion of the last item reloads the count and both start addresses, and the channel stays enabled.
- R10: A bus error on either access sets the error flag, clears enable and ends all requests. A failed read is not followed by its write.
- R11: Writing ones to the flag-clear register clears the matching flags. A flag being set in the same cycle wins.
- R12: `irq` is high while any flag is set together with its interrupt enable.
- R13: While the channel is enabled, writes to the base, count and non-enable control fields are ignored. A control write with bit 0 clear stops the channel at the end of the current item.
- R14: A bus request holds its address, direction, size and write data until `bus_ack` or `bus_err` is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 3 | Register write index |
| cfg_wdata | input | 32 | Register write data |
| cfg_raddr | input | 3 | Register read index |
| cfg_rdata | output | 32 | Register read data (combinational) |
| dreq | input | 1 | Peripheral request line; its rising edge paces items |
| bus_req | output | 1 | Access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Access byte address |
| bus_size | output | 2 | Access size code |
| bus_wdata | output | 32 | Write data, low-aligned |
| bus_rdata | input | 32 | Read data, low-aligned |
| bus_ack | input | 1 | Access completed |
| bus_err | input | 1 | Access failed |
| irq | output | 1 | Interrupt |

## Verification
The bench sweeps every combination of source size, destination size and the two increment switches in a free-running copy. A design that used the wrong step or the wrong truncation, or that let a fixed address drift, leaves destination bytes that differ from the arithmetic model. The odd count of three tests the midpoint rule: an off-by-one in the midpoint compare would report the midpoint one item early or not at all. Request-paced runs check that idle time moves nothing and that one pulse moves exactly one item. They also check that configuration writes made while the channel is running are dropped, since a design that accepted them would show the new value on read-back. Circular reload is shown by changing a source byte after a wrap and finding it at the destination base. A design that did not reload the addresses would write past the end of the buffer instead. Error tests check that a failed read is never followed by a write.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int REG_IDX_W = 3;
  localparam logic [REG_IDX_W-1:0] RI_CTRL = 3'd0;
  localparam logic [REG_IDX_W-1:0] RI_SRC  = 3'd1;
  localparam logic [REG_IDX_W-1:0] RI_DST  = 3'd2;
  localparam logic [REG_IDX_W-1:0] RI_CNT  = 3'd3;
  localparam logic [REG_IDX_W-1:0] RI_FLAG = 3'd4;
  localparam logic [REG_IDX_W-1:0] RI_FCLR = 3'd5;

  localparam int CTRL_W = 14;
  localparam int FLAG_N = 3;
  localparam int FL_DONE = 0;
  localparam int FL_HALF = 1;
  localparam int FL_ERR  = 2;

  // Control word layout, most significant field first.
  typedef struct packed {
    logic       ie_err;
    logic       ie_half;
    logic       ie_done;
    logic [1:0] prio;
    logic [1:0] dst_size;
    logic [1:0] src_size;
    logic       dst_inc;
    logic       src_inc;
    logic       circ;
    logic       free_run;
    logic       en;
  } ctrl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RD, ST_WR} xfer_st_e;

  // Address step for an item of the given size code.
  function automatic logic [2:0] size_step(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // Keep only the bytes that belong to an item of the given size.
  function automatic logic [31:0] size_trim(input logic [1:0] sz, input logic [31:0] d);
    case (sz)
      2'd0:    return {24'd0, d[7:0]};
      2'd1:    return {16'd0, d[15:0]};
      default: return d;
    endcase
  endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_IDX_W-1:0] wr_idx,
  input  logic [31:0]          wr_data,
  input  logic [REG_IDX_W-1:0] rd_idx,
  output logic [31:0]          rd_data,
  input  logic [CNT_W-1:0]     rem_cnt,
  input  logic [FLAG_N-1:0]    flag_set,
  input  logic                 en_clr,
  output ctrl_t                ctrl,
  output logic [ADDR_W-1:0]    src_base,
  output logic [ADDR_W-1:0]    dst_base,
  output logic [CNT_W-1:0]     cnt_base,
  output logic [FLAG_N-1:0]    flags,
  output logic                 irq
);

  logic wr_ctrl, wr_src, wr_dst, wr_cnt, wr_fclr;
  ctrl_t ctrl_in;
  logic [FLAG_N-1:0] flag_clr;
  logic [FLAG_N-1:0] flag_ie;

  always_comb begin
    wr_ctrl  = wr_en && (wr_idx == RI_CTRL);
    wr_src   = wr_en && (wr_idx == RI_SRC);
    wr_dst   = wr_en && (wr_idx == RI_DST);
    wr_cnt   = wr_en && (wr_idx == RI_CNT);
    wr_fclr  = wr_en && (wr_idx == RI_FCLR);
    ctrl_in  = ctrl_t'(wr_data[CTRL_W-1:0]);
    flag_clr = wr_fclr ? wr_data[FLAG_N-1:0] : '0;
  end

  // Control: whole word while idle, only a stop request while running.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else begin
      if (wr_ctrl) begin
        if (!ctrl.en) begin
          ctrl    <= ctrl_in;
          ctrl.en <= ctrl_in.en && (cnt_base != '0);
        end else if (!ctrl_in.en) begin
          ctrl.en <= 1'b0;
        end
      end
      if (en_clr) ctrl.en <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_base <= '0;
      dst_base <= '0;
      cnt_base <= '0;
    end else if (!ctrl.en) begin
      if (wr_src) src_base <= wr_data[ADDR_W-1:0];
      if (wr_dst) dst_base <= wr_data[ADDR_W-1:0];
      if (wr_cnt) cnt_base <= wr_data[CNT_W-1:0];
    end
  end

  // Sticky flags: a new event outranks a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~flag_clr) | flag_set;
  end

  always_comb begin
    case (rd_idx)
      RI_CTRL: rd_data = 32'(ctrl);
      RI_SRC:  rd_data = 32'(src_base);
      RI_DST:  rd_data = 32'(dst_base);
      RI_CNT:  rd_data = 32'(rem_cnt);
      RI_FLAG: rd_data = 32'(flags);
      default: rd_data = '0;
    endcase
  end

  assign flag_ie = {ctrl.ie_err, ctrl.ie_half, ctrl.ie_done};
  assign irq     = |(flags & flag_ie);

endmodule

// File: rtl/dma_chan_addr.sv
module dma_chan_addr
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              step,
  input  logic              inc,
  input  logic [1:0]        size,
  output logic [ADDR_W-1:0] addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           addr <= '0;
    else if (load)        addr <= base;
    else if (step && inc) addr <= addr + ADDR_W'(size_step(size));
  end

endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              free_run,
  input  logic              circ,
  input  logic [1:0]        src_size,
  input  logic [1:0]        dst_size,
  input  logic [CNT_W-1:0]  cnt_base,
  input  logic              dreq,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_ack,
  input  logic              bus_err,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic [31:0]       bus_wdata,
  output logic              addr_load,
  output logic              item_done,
  output logic              item_last,
  output logic [CNT_W-1:0]  rem_cnt,
  output logic [FLAG_N-1:0] flag_set,
  output logic              en_clr
);

  xfer_st_e st, st_nx;
  logic [CNT_W-1:0] rem_nx, rem_dec, half_mark;
  logic [31:0] data_q;
  logic dreq_q, pend, take, dreq_rise, go_on;

  assign dreq_rise = dreq && !dreq_q;
  assign rem_dec   = rem_cnt - CNT_W'(1);
  assign half_mark = cnt_base >> 1;

  always_comb begin
    st_nx     = st;
    rem_nx    = rem_cnt;
    addr_load = 1'b0;
    item_done = 1'b0;
    item_last = 1'b0;
    flag_set  = '0;
    en_clr    = 1'b0;
    take      = 1'b0;
    go_on     = 1'b0;
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_size  = 2'd0;
    bus_wdata = '0;
    case (st)
      ST_IDLE: begin
        if (en) begin
          addr_load = 1'b1;
          rem_nx    = cnt_base;
          st_nx     = free_run ? ST_RD : ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (!en) begin
          st_nx = ST_IDLE;
        end else if (pend) begin
          take  = 1'b1;
          st_nx = ST_RD;
        end
      end
      ST_RD: begin
        bus_req  = 1'b1;
        bus_addr = src_addr;
        bus_size = src_size;
        if (bus_err) begin
          flag_set[FL_ERR] = 1'b1;
          en_clr           = 1'b1;
          st_nx            = ST_IDLE;
        end else if (bus_ack) begin
          st_nx = ST_WR;
        end
      end
      default: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = dst_addr;
        bus_size  = dst_size;
        bus_wdata = size_trim(dst_size, data_q);
        if (bus_err) begin
          flag_set[FL_ERR] = 1'b1;
          en_clr           = 1'b1;
          st_nx            = ST_IDLE;
        end else if (bus_ack) begin
          item_done = 1'b1;
          if (rem_dec == half_mark) flag_set[FL_HALF] = 1'b1;
          if (rem_dec == '0) begin
            item_last         = 1'b1;
            flag_set[FL_DONE] = 1'b1;
            if (circ) begin
              addr_load = 1'b1;
              rem_nx    = cnt_base;
              go_on     = en;
            end else begin
              en_clr = 1'b1;
              rem_nx = '0;
            end
          end else begin
            rem_nx = rem_dec;
            go_on  = en;
          end
          st_nx = go_on ? (free_run ? ST_RD : ST_WAIT) : ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      rem_cnt <= '0;
      data_q  <= '0;
      dreq_q  <= 1'b0;
      pend    <= 1'b0;
    end else begin
      st      <= st_nx;
      rem_cnt <= rem_nx;
      dreq_q  <= dreq;
      if (st == ST_RD && bus_ack && !bus_err) data_q <= size_trim(src_size, bus_rdata);
      if (st == ST_IDLE) pend <= 1'b0;
      else               pend <= (pend && !take) || dreq_rise;
    end
  end

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_waddr,
  input  logic [31:0]       cfg_wdata,
  input  logic [2:0]        cfg_raddr,
  output logic [31:0]       cfg_rdata,
  input  logic              dreq,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_ack,
  input  logic              bus_err,
  output logic              irq
);

  localparam int SIDES = 2;

  ctrl_t ctrl;
  logic [ADDR_W-1:0] src_base, dst_base;
  logic [CNT_W-1:0]  cnt_base, rem_cnt;
  logic [FLAG_N-1:0] flags, flag_set;
  logic en_clr, addr_load, item_done, item_last;
  logic chan_en, chan_circ;

  logic [SIDES-1:0][ADDR_W-1:0] side_base, side_addr;
  logic [SIDES-1:0]             side_inc;
  logic [SIDES-1:0][1:0]        side_size;

  assign chan_en   = ctrl.en;
  assign chan_circ = ctrl.circ;

  assign side_base[0] = src_base;
  assign side_base[1] = dst_base;
  assign side_inc     = {ctrl.dst_inc, ctrl.src_inc};
  assign side_size[0] = ctrl.src_size;
  assign side_size[1] = ctrl.dst_size;

  dma_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_idx   (cfg_waddr),
    .wr_data  (cfg_wdata),
    .rd_idx   (cfg_raddr),
    .rd_data  (cfg_rdata),
    .rem_cnt  (rem_cnt),
    .flag_set (flag_set),
    .en_clr   (en_clr),
    .ctrl     (ctrl),
    .src_base (src_base),
    .dst_base (dst_base),
    .cnt_base (cnt_base),
    .flags    (flags),
    .irq      (irq)
  );

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    dma_chan_addr #(.ADDR_W(ADDR_W)) u_addr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (addr_load),
      .base  (side_base[g]),
      .step  (item_done),
      .inc   (side_inc[g]),
      .size  (side_size[g]),
      .addr  (side_addr[g])
    );
  end

  dma_chan_fsm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (ctrl.en),
    .free_run  (ctrl.free_run),
    .circ      (ctrl.circ),
    .src_size  (ctrl.src_size),
    .dst_size  (ctrl.dst_size),
    .cnt_base  (cnt_base),
    .dreq      (dreq),
    .src_addr  (side_addr[0]),
    .dst_addr  (side_addr[1]),
    .bus_rdata (bus_rdata),
    .bus_ack   (bus_ack),
    .bus_err   (bus_err),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .addr_load (addr_load),
    .item_done (item_done),
    .item_last (item_last),
    .rem_cnt   (rem_cnt),
    .flag_set  (flag_set),
    .en_clr    (en_clr)
  );

endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_ack,
  input logic              bus_err,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic [31:0]       bus_wdata,
  input logic              chan_en,
  input logic              chan_circ,
  input logic              item_last,
  input logic [CNT_W-1:0]  cnt_base,
  input logic [CNT_W-1:0]  rem_cnt,
  input logic [ADDR_W-1:0] src_base,
  input logic [2:0]        flags
);

  a_r14_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack && !bus_err |=> bus_req && $stable(bus_addr) && $stable(bus_we)
                                        && $stable(bus_size) && $stable(bus_wdata));

  a_r7_last_disables: assert property (@(posedge clk) disable iff (!rst_n)
    item_last && !chan_circ |=> !chan_en && rem_cnt == '0);

  a_r7_last_flags: assert property (@(posedge clk) disable iff (!rst_n)
    item_last |=> flags[0]);

  a_r9_circ_reload: assert property (@(posedge clk) disable iff (!rst_n)
    item_last && chan_circ |=> rem_cnt == cnt_base);

  a_r10_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_err |=> !bus_req && !chan_en && flags[2]);

  a_r13_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en |=> $stable(src_base) && $stable(cnt_base));

  a_r2_no_empty_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chan_en) |-> cnt_base != '0);

endmodule

bind dma_chan_engine dma_chan_engine_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req   (bus_req),
  .bus_ack   (bus_ack),
  .bus_err   (bus_err),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_size  (bus_size),
  .bus_wdata (bus_wdata),
  .chan_en   (chan_en),
  .chan_circ (chan_circ),
  .item_last (item_last),
  .cnt_base  (cnt_base),
  .rem_cnt   (rem_cnt),
  .src_base  (src_base),
  .flags     (flags)
);

// File: tb/dma_chan_engine_tb.sv
`timescale 1ns/1ps
module dma_chan_engine_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_waddr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0] cfg_raddr = '0;
  logic [31:0] cfg_rdata;
  logic dreq = 1'b0;
  logic bus_req, bus_we;
  logic [31:0] bus_addr;
  logic [1:0] bus_size;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic bus_ack = 1'b0;
  logic bus_err = 1'b0;
  logic irq;

  int n_chk = 0;
  int n_err = 0;
  int wr_count = 0;
  int rd_count = 0;
  logic [1:0] last_rsz = 2'd3;
  logic [1:0] last_wsz = 2'd3;
  logic [7:0] mem  [256];
  logic [7:0] refm [256];

  always #2 clk = ~clk;

  dma_chan_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
    .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata), .dreq(dreq), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err), .irq(irq)
  );

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  // Memory model: one-cycle response; addresses with bit 31 set fail.
  always @(negedge clk) begin
    if (bus_ack || bus_err) begin
      bus_ack <= 1'b0;
      bus_err <= 1'b0;
    end else if (bus_req) begin
      if (bus_addr[31]) begin
        bus_err <= 1'b1;
      end else begin
        bus_ack <= 1'b1;
        if (bus_we) begin
          for (int k = 0; k < nbytes(bus_size); k++)
            mem[8'(bus_addr[7:0] + 8'(k))] = bus_wdata[8*k +: 8];
          wr_count++;
          last_wsz <= bus_size;
        end else begin
          for (int k = 0; k < 4; k++)
            bus_rdata[8*k +: 8] <= (k < nbytes(bus_size)) ? mem[8'(bus_addr[7:0] + 8'(k))] : 8'h00;
          rd_count++;
          last_rsz <= bus_size;
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_raddr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic pulse();
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    for (int i = 0; i < 2000; i++) begin
      reg_rd(3'd0, c);
      if (!c[0]) break;
    end
  endtask

  function automatic logic [31:0] ctl(input bit en, input bit fr, input bit circ, input bit si,
                                      input bit di, input logic [1:0] ss, input logic [1:0] ds,
                                      input logic [2:0] ie);
    return {18'd0, ie, 2'd0, ds, ss, di, si, circ, fr, en};
  endfunction

  // Arithmetic reference for one whole run.
  task automatic ref_run(input logic [7:0] sb, input logic [7:0] db, input int n,
                         input logic [1:0] ss, input logic [1:0] ds, input bit si, input bit di);
    for (int i = 0; i < n; i++) begin
      logic [7:0] sa, da;
      sa = si ? 8'(sb + i * nbytes(ss)) : sb;
      da = di ? 8'(db + i * nbytes(ds)) : db;
      for (int k = 0; k < nbytes(ds); k++)
        refm[8'(da + 8'(k))] = (k < nbytes(ss)) ? refm[8'(sa + 8'(k))] : 8'h00;
    end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 256; i++) begin
      mem[i]  = 8'(i * 37 + seed * 11 + 1);
      refm[i] = mem[i];
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int run, bad, w0;
    fill(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    reg_rd(3'd0, v); check("R1 ctrl after reset", v, 0);
    reg_rd(3'd3, v); check("R1 count after reset", v, 0);
    reg_rd(3'd4, v); check("R1 flags after reset", v, 0);
    check("R1 irq/bus_req after reset", {irq, bus_req}, 0);

    // R2: enable with zero count is refused
    reg_wr(3'd3, 0);
    reg_wr(3'd0, ctl(1, 1, 0, 1, 1, 2, 2, 0));
    repeat (10) @(negedge clk);
    reg_rd(3'd0, v); check("R2 enable refused at count 0", v[0], 0);
    check("R2 no access at count 0", rd_count + wr_count, 0);

    // R3 R5 R6 R7 R8: sweep sizes and increments, free-running, count 3
    run = 0;
    for (int ss = 0; ss < 3; ss++)
      for (int ds = 0; ds < 3; ds++)
        for (int si = 0; si < 2; si++)
          for (int di = 0; di < 2; di++) begin
            run++;
            fill(run);
            ref_run(8'h10, 8'h80, 3, 2'(ss), 2'(ds), si[0], di[0]);
            reg_wr(3'd1, 32'h10);
            reg_wr(3'd2, 32'h80);
            reg_wr(3'd3, 3);
            reg_wr(3'd0, ctl(1, 1, 0, si[0], di[0], 2'(ss), 2'(ds), 0));
            wait_idle();
            bad = 0;
            for (int a = 8'h70; a < 8'h9F; a++) if (mem[a] !== refm[a]) bad++;
            check($sformatf("R3 R6 copy ss=%0d ds=%0d si=%0d di=%0d", ss, ds, si, di), bad, 0);
            check("R5 bus size codes", {last_rsz, last_wsz}, {2'(ss), 2'(ds)});
            reg_rd(3'd4, v); check("R7 R8 flags at end of count 3", v, 3);
            reg_rd(3'd3, v); check("R7 remaining count zero", v, 0);
            reg_wr(3'd5, 7);
          end

    // R4 R8 R12 R13: paced, word to fixed destination, count 6
    fill(99);
    reg_wr(3'd1, 32'h40);
    reg_wr(3'd2, 32'hA0);
    reg_wr(3'd3, 6);
    w0 = wr_count;
    reg_wr(3'd0, ctl(1, 0, 0, 1, 0, 2, 2, 3'b011));
    repeat (20) @(negedge clk);
    check("R4 no item without request", wr_count - w0, 0);
    pulse();
    check("R4 one item per pulse", wr_count - w0, 1);
    reg_rd(3'd3, v); check("R4 remaining after one pulse", v, 5);
    pulse();
    reg_rd(3'd4, v); check("R8 midpoint not yet after 2 of 6", v, 0);
    check("R12 irq low with no flag", irq, 0);
    pulse();
    reg_rd(3'd4, v); check("R8 midpoint after 3 of 6", v, 2);
    check("R12 irq on midpoint", irq, 1);
    reg_wr(3'd1, 32'h55);
    reg_rd(3'd1, v); check("R13 source write ignored while enabled", v, 32'h40);
    reg_wr(3'd3, 9);
    reg_rd(3'd3, v); check("R13 count write ignored while enabled", v, 3);
    pulse(); pulse(); pulse();
    check("R4 six pulses six items", wr_count - w0, 6);
    check("R6 fixed destination holds last word", {mem[8'hA3], mem[8'hA2], mem[8'hA1], mem[8'hA0]},
          {mem[8'h57], mem[8'h56], mem[8'h55], mem[8'h54]});
    reg_rd(3'd0, v); check("R7 enable cleared at end", v[0], 0);
    reg_rd(3'd4, v); check("R7 complete flag", v, 3);
    reg_wr(3'd5, 2);
    reg_rd(3'd4, v); check("R11 clear midpoint only", v, 1);
    check("R12 irq from complete flag", irq, 1);
    reg_wr(3'd5, 1);
    reg_rd(3'd4, v); check("R11 clear complete", v, 0);
    check("R12 irq low after clear", irq, 0);

    // R9: circular ring of 2 bytes
    fill(7);
    reg_wr(3'd1, 32'h20);
    reg_wr(3'd2, 32'h90);
    reg_wr(3'd3, 2);
    reg_wr(3'd0, ctl(1, 0, 1, 1, 1, 0, 0, 0));
    pulse(); pulse();
    reg_rd(3'd4, v); check("R9 complete flag on wrap", v[0], 1);
    reg_rd(3'd0, v); check("R9 still enabled after wrap", v[0], 1);
    reg_rd(3'd3, v); check("R9 count reloaded", v, 2);
    mem[8'h20] = 8'hA5;
    w0 = mem[8'h91];
    pulse();
    check("R9 addresses reloaded", mem[8'h90], 8'hA5);
    check("R9 second slot untouched", mem[8'h91], w0);
    check("R9 nothing past ring end", mem[8'h92], refm[8'h92]);
    reg_wr(3'd0, 0);
    repeat (4) @(negedge clk);
    reg_rd(3'd0, v); check("R13 stop write clears enable", v[0], 0);
    reg_wr(3'd5, 7);

    // R10: read error
    reg_wr(3'd1, 32'h8000_0010);
    reg_wr(3'd2, 32'hC0);
    reg_wr(3'd3, 4);
    w0 = wr_count;
    reg_wr(3'd0, ctl(1, 1, 0, 1, 1, 2, 2, 3'b100));
    repeat (20) @(negedge clk);
    check("R10 no write after failed read", wr_count - w0, 0);
    reg_rd(3'd4, v); check("R10 error flag", v, 4);
    reg_rd(3'd0, v); check("R10 enable cleared", v[0], 0);
    check("R10 no request, irq up", {bus_req, irq}, 2'b01);
    reg_wr(3'd5, 4);
    reg_rd(3'd4, v); check("R11 error flag cleared", v, 0);

    // R10: write error after a good read
    reg_wr(3'd1, 32'h10);
    reg_wr(3'd2, 32'h8000_0000);
    w0 = rd_count;
    reg_wr(3'd0, ctl(1, 1, 0, 1, 1, 2, 2, 0));
    repeat (20) @(negedge clk);
    check("R10 single read before failed write", rd_count - w0, 1);
    reg_rd(3'd4, v); check("R10 error flag on write", v, 4);

    finish_run();
  end

endmodule